// File: doc/BRIEF.md
# Combinational Processing-Element Array Accelerator

This block is a small coarse-grained reconfigurable array in which every processing element is plain combinational logic. The array holds no registers and takes no clock. Storage sits only at its boundary. A launch register feeds the first column. A gather register captures the outputs of the last column. One constant register per row supplies a fixed operand. Before runtime, software writes a static configuration word for each element. The word picks the ALU operation and the source of each of the two operands.

A computation starts from the start input once every row word of the launch register has been written since the previous launch. The array then settles for a programmable number of cycles. When that count runs out, the gather register loads the final column and a one-cycle done pulse follows. Data moves strictly from column to column. Each element reads the element on its left in the previous column, whose east link reaches it, or the element one row below in the previous column, whose north-east link reaches it. An operand that would come from outside the array reads as zero.

Top module: `cgra_comb_array`

## Requirements
- R1: After reset, `result` is all zero and `done` is low.
- R2: The ALU opcode is 3 bits: 0 a+b, 1 a-b (both modulo 2^DW), 2 a AND b, 3 a OR b, 4 a XOR b, 5 a shifted left by b[4:0], 6 a shifted right logically by b[4:0], 7 pass a. A shift by DW or more gives zero. The shift field is b[4:0] when DW is 24.
- R3: A configuration word is {op[6:4], sel_a[3:2], sel_b[1:0]}, written to element index col*ROWS+row. Each operand select takes one of four codes: 0 is the west link (same row, previous column), 1 is the diagonal link (row-1, previous column), 2 is the row's constant register, and 3 is zero.
- R4: For column 0, the west link of row r is launch word r and the diagonal link is launch word r-1. The diagonal link of row 0 reads zero in every column.
- R5: A start is accepted only when all ROWS launch words have been written since the last launch. An earlier start is dropped and is not remembered.
- R6: With settle value D sampled at the launch edge, `done` is high for exactly one cycle. That cycle begins D+1 clock edges after the launch edge, and `result` holds the new values in that same cycle.
- R7: `result` changes only in a cycle where `done` is high and holds its value at all other times.
- R8: While a computation settles, including its launch edge, writes to configuration, constant and launch registers are ignored.
- R9: A start made while a computation settles is held. The next launch then happens one edge after all launch words have been rewritten, with no further start.
- R10: `result[r*DW +: DW]` carries the last-column element of row r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Write strobe for one element's configuration |
| cfg_idx | input | 6 | Element index, col*ROWS+row |
| cfg_word | input | 7 | Configuration word {op, sel_a, sel_b} |
| cst_we | input | 1 | Write strobe for a row constant |
| cst_row | input | 3 | Row of the constant |
| cst_word | input | 24 | Constant value |
| in_we | input | 1 | Write strobe for a launch word |
| in_row | input | 3 | Row of the launch word |
| in_word | input | 24 | Launch word value |
| settle | input | 8 | Settle cycle count, sampled at launch |
| start | input | 1 | Launch request |
| result | output | 192 | Gather register, row r at bits r*24 upward |
| done | output | 1 | One-cycle pulse when the gather register has loaded |

## Verification
The done pulse and the new result are due D+1 edges after the edge that samples start. A held launch instead falls one edge after the edge that writes the last launch word, so its done comes D+2 edges after that write. The bench keeps a running edge counter. It drives all inputs on falling edges and reads done and result only on falling edges, so it takes the difference from the launch edge and compares it with these figures. Ignored writes and dropped starts are checked at the ports. The bench waits well past any possible done time for a pulse that must not come. It then confirms that a later result still matches the unchanged model.

// File: rtl/cgra_pkg.sv
package cgra_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_WEST  = 2'd0,
    SRC_DIAG  = 2'd1,
    SRC_CONST = 2'd2,
    SRC_ZERO  = 2'd3
  } src_sel_e;

  typedef struct packed {
    alu_op_e  op;
    src_sel_e sel_a;
    src_sel_e sel_b;
  } pe_cfg_t;

  localparam int CFG_W = $bits(pe_cfg_t);

endpackage

// File: rtl/cgra_pe.sv
module cgra_pe
  import cgra_pkg::*;
#(
  parameter int DW = 24
) (
  input  pe_cfg_t          cfg_i,
  input  logic [DW-1:0]    west_i,
  input  logic [DW-1:0]    diag_i,
  input  logic [DW-1:0]    cst_i,
  output logic [DW-1:0]    res_o
);

  localparam int SH_W = $clog2(DW);

  logic [DW-1:0]   opa;
  logic [DW-1:0]   opb;
  logic [SH_W-1:0] shamt;

  function automatic logic [DW-1:0] pick_src(src_sel_e s, logic [DW-1:0] w,
                                             logic [DW-1:0] d, logic [DW-1:0] k);
    logic [DW-1:0] v;
    case (s)
      SRC_WEST:  v = w;
      SRC_DIAG:  v = d;
      SRC_CONST: v = k;
      default:   v = '0;
    endcase
    return v;
  endfunction

  always_comb begin
    opa   = pick_src(cfg_i.sel_a, west_i, diag_i, cst_i);
    opb   = pick_src(cfg_i.sel_b, west_i, diag_i, cst_i);
    shamt = opb[SH_W-1:0];
  end

  always_comb begin
    case (cfg_i.op)
      OP_ADD:  res_o = opa + opb;
      OP_SUB:  res_o = opa - opb;
      OP_AND:  res_o = opa & opb;
      OP_OR:   res_o = opa | opb;
      OP_XOR:  res_o = opa ^ opb;
      OP_SHL:  res_o = opa << shamt;
      OP_SHR:  res_o = opa >> shamt;
      default: res_o = opa;
    endcase
  end

endmodule

// File: rtl/cgra_grid.sv
module cgra_grid
  import cgra_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 24
) (
  input  pe_cfg_t [ROWS*COLS-1:0]      cfg_i,
  input  logic    [ROWS-1:0][DW-1:0]   lr_i,
  input  logic    [ROWS-1:0][DW-1:0]   cst_i,
  output logic    [ROWS-1:0][DW-1:0]   col_o
);

  // stage[0] is the launch register, stage[c+1] the outputs of column c
  logic [COLS:0][ROWS-1:0][DW-1:0] stage;

  assign stage[0] = lr_i;
  assign col_o    = stage[COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [DW-1:0] diag;
      if (r == 0) begin : g_edge
        assign diag = '0;
      end else begin : g_link
        assign diag = stage[c][r-1];
      end

      cgra_pe #(.DW(DW)) pe_i (
        .cfg_i  (cfg_i[c*ROWS+r]),
        .west_i (stage[c][r]),
        .diag_i (diag),
        .cst_i  (cst_i[r]),
        .res_o  (stage[c+1][r])
      );
    end
  end

endmodule

// File: rtl/cgra_seq.sv
module cgra_seq #(
  parameter int ROWS  = 8,
  parameter int DLY_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     in_we_i,
  input  logic [$clog2(ROWS)-1:0]  in_row_i,
  input  logic [DLY_W-1:0]         settle_i,
  output logic                     wr_ok_o,
  output logic                     busy_o,
  output logic                     capture_o,
  output logic                     done_o
);

  logic [ROWS-1:0]  vld_q, vld_d;
  logic [ROWS-1:0]  row_hot;
  logic             pend_q, pend_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             go;
  logic             fire;

  always_comb begin
    row_hot           = '0;
    row_hot[in_row_i] = 1'b1;
    go                = !busy_q && (start_i || pend_q) && (&vld_q);
    fire              = busy_q && (cnt_q == '0);
    wr_ok_o           = !busy_q && !go;
  end

  always_comb begin
    vld_d  = vld_q;
    pend_d = pend_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = fire;
    if (go) begin
      vld_d  = '0;
      pend_d = 1'b0;
      busy_d = 1'b1;
      cnt_d  = settle_i;
    end else begin
      if (wr_ok_o && in_we_i) vld_d = vld_q | row_hot;
      if (busy_q && start_i)  pend_d = 1'b1;
      if (fire)               busy_d = 1'b0;
      else if (busy_q)        cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      pend_q <= pend_d;
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o    = busy_q;
  assign capture_o = fire;
  assign done_o    = done_q;

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: a computation ends only together with its done pulse
  a_r6_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R5: a computation starts only from a complete launch register
  a_r5_launch_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(&vld_q));

  // R9: a held request is dropped only by a launch
  a_r9_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $rose(busy_q));

endmodule

// File: rtl/cgra_comb_array.sv
module cgra_comb_array
  import cgra_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DW    = 24,
  parameter int DLY_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [$clog2(ROWS*COLS)-1:0]    cfg_idx,
  input  logic [CFG_W-1:0]                cfg_word,
  input  logic                            cst_we,
  input  logic [$clog2(ROWS)-1:0]         cst_row,
  input  logic [DW-1:0]                   cst_word,
  input  logic                            in_we,
  input  logic [$clog2(ROWS)-1:0]         in_row,
  input  logic [DW-1:0]                   in_word,
  input  logic [DLY_W-1:0]                settle,
  input  logic                            start,
  output logic [ROWS*DW-1:0]              result,
  output logic                            done
);

  localparam int NPE = ROWS * COLS;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  pe_cfg_t [NPE-1:0]          cfg_q;
  logic    [ROWS-1:0][DW-1:0] cst_q;
  logic    [ROWS-1:0][DW-1:0] lr_q;
  logic    [ROWS-1:0][DW-1:0] gather_q;
  logic    [ROWS-1:0][DW-1:0] col_out;

  logic wr_ok, busy, capture;
  logic cfg_en, cst_en, lr_en;

  cgra_seq #(.ROWS(ROWS), .DLY_W(DLY_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_i),
    .start_i   (start),
    .in_we_i   (in_we),
    .in_row_i  (in_row),
    .settle_i  (settle),
    .wr_ok_o   (wr_ok),
    .busy_o    (busy),
    .capture_o (capture),
    .done_o    (done)
  );

  cgra_grid #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) grid_i (
    .cfg_i (cfg_q),
    .lr_i  (lr_q),
    .cst_i (cst_q),
    .col_o (col_out)
  );

  always_comb begin
    cfg_en = cfg_we && wr_ok;
    cst_en = cst_we && wr_ok;
    lr_en  = in_we  && wr_ok;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      cfg_q <= '0;
    else if (cfg_en) cfg_q[cfg_idx] <= pe_cfg_t'(cfg_word);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      cst_q <= '0;
    else if (cst_en) cst_q[cst_row] <= cst_word;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)     lr_q <= '0;
    else if (lr_en) lr_q[in_row] <= in_word;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       gather_q <= '0;
    else if (capture) gather_q <= col_out;
  end

  assign result = gather_q;

  // R7: the visible result moves only with a done pulse
  a_r7_result_on_done: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(result) |-> done);

  // R8: launch words stay frozen while the array settles
  a_r8_launch_frozen: assert property (@(posedge clk) disable iff (!rst_i)
    busy |=> $stable(lr_q));

  // R8: configuration and constants stay frozen while the array settles
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_i)
    busy |=> ($stable(cfg_q) && $stable(cst_q)));

endmodule

// File: tb/cgra_comb_array_tb.sv
module cgra_comb_array_tb_top;

  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int DW   = 24;
  localparam int NPE  = ROWS * COLS;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 cfg_we, cst_we, in_we, start;
  logic [5:0]           cfg_idx;
  logic [6:0]           cfg_word;
  logic [2:0]           cst_row, in_row;
  logic [DW-1:0]        cst_word, in_word;
  logic [7:0]           settle;
  logic [ROWS*DW-1:0]   result;
  logic                 done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [6:0]    m_cfg [NPE];
  logic [DW-1:0] m_cst [ROWS];
  logic [DW-1:0] m_lr  [ROWS];
  logic [DW-1:0] m_exp [ROWS];

  cgra_comb_array dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word),
    .cst_we(cst_we), .cst_row(cst_row), .cst_word(cst_word),
    .in_we(in_we), .in_row(in_row), .in_word(in_word),
    .settle(settle), .start(start), .result(result), .done(done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    report();
  end

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] alu(logic [2:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << b[4:0];
      3'd6: return a >> b[4:0];
      default: return a;
    endcase
  endfunction

  function automatic logic [DW-1:0] src(logic [1:0] s, logic [DW-1:0] w,
                                        logic [DW-1:0] d, logic [DW-1:0] k);
    case (s)
      2'd0: return w;
      2'd1: return d;
      2'd2: return k;
      default: return '0;
    endcase
  endfunction

  task automatic compute_ref();
    logic [DW-1:0] prev [ROWS];
    logic [DW-1:0] cur  [ROWS];
    for (int r = 0; r < ROWS; r++) prev[r] = m_lr[r];
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        logic [6:0]    w;
        logic [DW-1:0] d, a, b;
        w = m_cfg[c*ROWS+r];
        d = (r == 0) ? '0 : prev[r-1];
        a = src(w[3:2], prev[r], d, m_cst[r]);
        b = src(w[1:0], prev[r], d, m_cst[r]);
        cur[r] = alu(w[6:4], a, b);
      end
      for (int r = 0; r < ROWS; r++) prev[r] = cur[r];
    end
    for (int r = 0; r < ROWS; r++) m_exp[r] = prev[r];
  endtask

  task automatic cfg_wr(int idx, logic [6:0] w, bit upd);
    @(negedge clk); cfg_we = 1'b1; cfg_idx = idx[5:0]; cfg_word = w;
    @(posedge clk); if (upd) m_cfg[idx] = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cst_wr(int row, logic [DW-1:0] v, bit upd);
    @(negedge clk); cst_we = 1'b1; cst_row = row[2:0]; cst_word = v;
    @(posedge clk); if (upd) m_cst[row] = v;
    @(negedge clk); cst_we = 1'b0;
  endtask

  task automatic in_wr(int row, logic [DW-1:0] v, bit upd);
    @(negedge clk); in_we = 1'b1; in_row = row[2:0]; in_word = v;
    @(posedge clk); if (upd) m_lr[row] = v;
    @(negedge clk); in_we = 1'b0;
  endtask

  task automatic load_inputs();
    for (int r = 0; r < ROWS; r++) in_wr(r, DW'($urandom), 1'b1);
  endtask

  // waits at falling edges for done; returns the edge count at that point
  task automatic wait_done(output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin at = cyc; break; end
    end
  endtask

  task automatic check_result(string tag);
    compute_ref();
    for (int r = 0; r < ROWS; r++) chk(tag, result[r*DW +: DW], m_exp[r]);
  endtask

  task automatic launch_and_check(int d, string tag);
    int l0, at;
    @(negedge clk); settle = d[7:0]; start = 1'b1;
    @(posedge clk); l0 = cyc + 1;
    @(negedge clk); start = 1'b0;
    wait_done(at);
    chk("R6 done delay", DW'(at - l0), DW'(d + 1));
    check_result(tag);
    @(negedge clk);
    chk("R6 done single cycle", DW'(done), DW'(0));
  endtask

  task automatic quiet_window(int n, string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk(tag, DW'(seen), DW'(0));
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 0; cst_we = 0; in_we = 0; start = 0;
    cfg_idx = '0; cfg_word = '0; cst_row = '0; cst_word = '0;
    in_row = '0; in_word = '0; settle = '0;
    for (int i = 0; i < NPE; i++) m_cfg[i] = '0;
    for (int r = 0; r < ROWS; r++) begin m_cst[r] = '0; m_lr[r] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 result after reset", result[DW-1:0] | result[ROWS*DW-1 -: DW], '0);
    chk("R1 done after reset", DW'(done), DW'(0));

    // R2: each opcode uniformly across the array
    for (int op = 0; op < 8; op++) begin
      for (int i = 0; i < NPE; i++)
        cfg_wr(i, {op[2:0], 2'($urandom), 2'($urandom)}, 1'b1);
      for (int r = 0; r < ROWS; r++)
        cst_wr(r, (op >= 5) ? DW'($urandom_range(0, 30)) : DW'($urandom), 1'b1);
      load_inputs();
      launch_and_check(3, "R2 opcode sweep");
    end

    // R3: mixed configurations, settle values 0..7 and the maximum
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < NPE; i++) cfg_wr(i, 7'($urandom), 1'b1);
      for (int r = 0; r < ROWS; r++) cst_wr(r, DW'($urandom), 1'b1);
      load_inputs();
      launch_and_check((t == 11) ? 255 : (t % 8), "R3 mixed mapping");
    end

    // R4: diagonal chain only -> everything comes from outside the edge
    for (int i = 0; i < NPE; i++) cfg_wr(i, {3'd7, 2'd1, 2'd0}, 1'b1);
    load_inputs();
    launch_and_check(2, "R4 edge reads zero");
    chk("R4 top row zero", result[(ROWS-1)*DW +: DW], '0);

    // R10: west chain only -> row r of result equals launch word r
    for (int i = 0; i < NPE; i++) cfg_wr(i, {3'd7, 2'd0, 2'd0}, 1'b1);
    load_inputs();
    launch_and_check(1, "R10 row placement");
    for (int r = 0; r < ROWS; r++) chk("R10 launch word r", result[r*DW +: DW], m_lr[r]);

    // R7: result holds when no done, even across new launch writes
    begin
      logic [ROWS*DW-1:0] held;
      held = result;
      in_wr(0, 24'h123456, 1'b1);
      repeat (8) @(negedge clk);
      checks++;
      if (result !== held) begin
        fails++;
        $display("FAIL R7 result held: actual %0h expected %0h", result, held);
      end
    end

    // R5: start with an incomplete launch register is dropped
    for (int i = 0; i < NPE; i++) cfg_wr(i, 7'($urandom), 1'b1);
    for (int r = 1; r < ROWS - 1; r++) in_wr(r, DW'($urandom), 1'b1);
    @(negedge clk); settle = 8'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    quiet_window(20, "R5 no launch when incomplete");
    in_wr(ROWS - 1, DW'($urandom), 1'b1);
    quiet_window(12, "R5 dropped start not remembered");
    launch_and_check(2, "R5 launch once complete");

    // R8 and R9: writes and a start during settling
    for (int i = 0; i < NPE; i++) cfg_wr(i, 7'($urandom), 1'b1);
    load_inputs();
    begin
      int l0, at;
      @(negedge clk); settle = 8'd30; start = 1'b1;
      @(posedge clk); l0 = cyc + 1;
      @(negedge clk); start = 1'b0;
      repeat (2) @(negedge clk);
      cfg_wr(NPE - 1, 7'h5A, 1'b0);
      cfg_wr(NPE - 2, 7'h33, 1'b0);
      cst_wr(ROWS - 1, 24'hABCDEF, 1'b0);
      in_wr(ROWS - 1, 24'h0F0F0F, 1'b0);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done(at);
      chk("R8 done delay with writes", DW'(at - l0), DW'(31));
      check_result("R8 writes while settling ignored");
      // R9: rewrite all launch words with no new start
      for (int r = 0; r < ROWS - 1; r++) in_wr(r, DW'($urandom), 1'b1);
      @(negedge clk); in_we = 1'b1; in_row = 3'(ROWS - 1); in_word = DW'($urandom);
      @(posedge clk); m_lr[ROWS-1] = in_word; l0 = cyc + 1;
      @(negedge clk); in_we = 1'b0;
      wait_done(at);
      chk("R9 held launch timing", DW'(at - l0), DW'(32));
      check_result("R9 held launch result, R8 old config kept");
    end

    report();
  end

endmodule